// File: doc/BRIEF.md
# Pin Input/Output Cell

This block models a single pin cell of a programmable logic fabric. Its input side takes the external pin value and hands it to the logic array in one of three ways: through an edge-triggered flip-flop, through a latch that is transparent while its clock is high, or directly with no storage. The capture clock arrives from a global clock selector outside the block. A polarity bit lets capture follow either edge of that clock.

The output side picks one of several logic-cell outputs, inverts it if asked, and drives a modelled three-state buffer. The buffer appears as a data bit and an enable bit. When the pin is wired as a dedicated output, the capture element is no longer needed for the pin. It can then take an internal sum signal instead and act as an extra buried register feeding the array. Setting the `HAS_OUT` parameter to 0 gives a dedicated input cell, in which the whole output path is tied off.

Top module: `pin_io_cell`

## Requirements
- R1: While `rst_n` is low, the flip-flop and the latch are both cleared at once, so `arr_in` reads 0 in modes 01 and 10.
- R2: In mode `cap_mode`=01 (flip-flop), `arr_in` takes the capture data on each rising edge of the effective capture clock and holds it between those edges.
- R3: In mode `cap_mode`=10 (latch), `arr_in` follows the capture data while the effective clock is high and keeps the last value once the clock falls.
- R4: In modes `cap_mode`=00 and 11 (bypass), `arr_in` follows the capture data combinationally, with no clock involved.
- R5: With `clk_inv`=1 the effective capture clock is `cap_clk` inverted: the flip-flop loads on falling `cap_clk`, and the latch is transparent while `cap_clk` is low.
- R6: When the output is driven, `pad_o` equals `lc_out[src_sel]` XOR `out_inv`.
- R7: `pad_oe` equals `oe`. When `oe`=0, `pad_o` reads 0 (the undriven pin), and the input path still captures `pad_i`.
- R8: With `ded_out`=1 the capture data is `sum_d` and `pad_i` has no effect on `arr_in`. With `ded_out`=0 the capture data is `pad_i`.
- R9: With `HAS_OUT`=0, `pad_oe` and `pad_o` stay 0 whatever `oe`, `lc_out` and `out_inv` are, and the input path works unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_clk | input | 1 | Capture clock chosen by the global selector |
| clk_inv | input | 1 | 1 inverts the capture clock polarity |
| rst_n | input | 1 | Asynchronous active-low clear of the capture element |
| cap_mode | input | 2 | 00/11 bypass, 01 flip-flop, 10 latch |
| ded_out | input | 1 | Pin is a dedicated output; capture element becomes a buried register fed by `sum_d` |
| pad_i | input | 1 | External pin value |
| sum_d | input | 1 | Internal sum signal for buried-register use |
| lc_out | input | NSRC | Candidate logic-cell outputs |
| src_sel | input | SELW | Index of the logic cell driving the pin |
| out_inv | input | 1 | Output polarity inversion |
| oe | input | 1 | Output enable for the three-state driver |
| arr_in | output | 1 | Value fed back to the logic array |
| pad_o | output | 1 | Driven pin data (0 when undriven) |
| pad_oe | output | 1 | Driver enable; 0 means the pin is high impedance |

## Verification
A stuck or wrong capture element shows on `arr_in`. In flip-flop mode it appears at the first effective clock edge after the data changes. In latch mode it appears while the clock is high and across the following low phase. A clock polarity fault shows as a load half a period early or late. If the buried-register select is wrong, `arr_in` follows the pin rather than `sum_d`. Output-path faults (wrong source bit, missing inversion, enable leaking through) show combinationally on `pad_o` and `pad_oe` in the same cycle.

// File: rtl/pin_io_cell.sv
module pin_io_cell #(
  parameter int NSRC = 8,
  parameter bit HAS_OUT = 1'b1,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            cap_clk,
  input  logic            clk_inv,
  input  logic            rst_n,
  input  logic [1:0]      cap_mode,
  input  logic            ded_out,
  input  logic            pad_i,
  input  logic            sum_d,
  input  logic [NSRC-1:0] lc_out,
  input  logic [SELW-1:0] src_sel,
  input  logic            out_inv,
  input  logic            oe,
  output logic            arr_in,
  output logic            pad_o,
  output logic            pad_oe
);

  localparam logic [1:0] M_FLOP  = 2'b01;
  localparam logic [1:0] M_LATCH = 2'b10;

  logic eclk;
  logic cap_d;
  logic flop_q;
  logic lat_q;

  assign eclk  = cap_clk ^ clk_inv;
  assign cap_d = ded_out ? sum_d : pad_i;

  always_ff @(posedge eclk or negedge rst_n) begin
    if (!rst_n) flop_q <= 1'b0;
    else        flop_q <= cap_d;
  end

  always_latch begin
    if (!rst_n)    lat_q = 1'b0;
    else if (eclk) lat_q = cap_d;
  end

  always_comb begin
    case (cap_mode)
      M_FLOP:  arr_in = flop_q;
      M_LATCH: arr_in = lat_q;
      default: arr_in = cap_d;
    endcase
  end

  generate
    if (HAS_OUT) begin : g_out
      logic src_bit;
      always_comb begin
        src_bit = 1'b0;
        if (int'(src_sel) < NSRC) src_bit = lc_out[src_sel];
      end
      assign pad_oe = oe;
      assign pad_o  = oe & (src_bit ^ out_inv);
    end else begin : g_noout
      assign pad_oe = 1'b0;
      assign pad_o  = 1'b0;
    end
  endgenerate

  AST_FLOP_LOAD: assert property (@(posedge eclk) disable iff (!rst_n)
    (cap_mode == M_FLOP) |=> (flop_q == $past(cap_d))); // R2

  AST_BURIED_SRC: assert property (@(posedge eclk) disable iff (!rst_n)
    (cap_mode == M_FLOP && ded_out && $stable(ded_out)) |=> (flop_q == $past(sum_d))); // R8

  AST_LATCH_OPEN: assert property (@(negedge eclk) disable iff (!rst_n)
    (cap_mode == M_LATCH) |-> (lat_q == cap_d)); // R3

  always_comb begin
    if (rst_n && (cap_mode == 2'b00 || cap_mode == 2'b11))
      AST_BYPASS_PASS: assert (arr_in == cap_d); // R4
    if (!pad_oe)
      AST_UNDRIVEN_LOW: assert (pad_o == 1'b0); // R7
  end

  always_ff @(posedge eclk) begin
    if (!rst_n)
      AST_RESET_CLEAR: assert (flop_q == 1'b0 && lat_q == 1'b0); // R1
  end

endmodule

// File: tb/tb_pin_io_cell.sv
module tb_pin_io_cell;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       clk_inv, rst_n, ded_out, pad_i, sum_d, out_inv, oe;
  logic [1:0] cap_mode;
  logic [7:0] lc_out;
  logic [2:0] src_sel;
  logic       arr_in, pad_o, pad_oe;
  logic       arr2, pad_o2, pad_oe2;

  pin_io_cell #(.NSRC(8), .HAS_OUT(1'b1)) dut (
    .cap_clk(clk), .clk_inv(clk_inv), .rst_n(rst_n), .cap_mode(cap_mode),
    .ded_out(ded_out), .pad_i(pad_i), .sum_d(sum_d), .lc_out(lc_out),
    .src_sel(src_sel), .out_inv(out_inv), .oe(oe),
    .arr_in(arr_in), .pad_o(pad_o), .pad_oe(pad_oe));

  pin_io_cell #(.NSRC(8), .HAS_OUT(1'b0)) dut_in (
    .cap_clk(clk), .clk_inv(clk_inv), .rst_n(rst_n), .cap_mode(cap_mode),
    .ded_out(ded_out), .pad_i(pad_i), .sum_d(sum_d), .lc_out(lc_out),
    .src_sel(src_sel), .out_inv(out_inv), .oe(oe),
    .arr_in(arr2), .pad_o(pad_o2), .pad_oe(pad_oe2));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // {src_sel, lc_out, out_inv, oe, exp_pad_o, exp_pad_oe}
  localparam logic [14:0] VEC [8] = '{
    {3'd0, 8'h01, 1'b0, 1'b1, 1'b1, 1'b1},
    {3'd3, 8'h08, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd7, 8'h7F, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd7, 8'h80, 1'b0, 1'b1, 1'b1, 1'b1},
    {3'd5, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1},
    {3'd2, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd2, 8'hFB, 1'b1, 1'b1, 1'b1, 1'b1},
    {3'd6, 8'h40, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic at_rise(int d);
    @(posedge clk); #(d);
  endtask

  initial begin
    clk_inv = 0; rst_n = 0; ded_out = 0; pad_i = 1; sum_d = 0;
    out_inv = 0; oe = 0; cap_mode = 2'b01; lc_out = '0; src_sel = '0;
    at_rise(5);
    chk("R1 reset flop", arr_in, 1'b0);
    cap_mode = 2'b10; #1;
    chk("R1 reset latch", arr_in, 1'b0);
    rst_n = 1;

    for (int i = 0; i < 8; i++) begin
      {src_sel, lc_out, out_inv, oe} = VEC[i][14:2];
      #2;
      chk("R6 pad_o vector", pad_o, VEC[i][1]);
      chk("R7 pad_oe vector", pad_oe, VEC[i][0]);
      chk("R9 input cell pad_o", pad_o2, 1'b0);
      chk("R9 input cell pad_oe", pad_oe2, 1'b0);
    end

    // R2 flip-flop, rising edge
    cap_mode = 2'b01; oe = 0; pad_i = 0;
    at_rise(5); pad_i = 1;
    #10; chk("R2 flop holds before edge", arr_in, 1'b0);
    at_rise(5); chk("R2 flop loads on rise", arr_in, 1'b1);
    chk("R7 capture while undriven", arr_in, 1'b1);
    chk("R9 input cell captures", arr2, 1'b1);

    // R3 latch, transparent high
    cap_mode = 2'b10; pad_i = 0;
    at_rise(5); pad_i = 1; #1;
    chk("R3 latch transparent", arr_in, 1'b1);
    #9; pad_i = 0; #1;
    chk("R3 latch holds when low", arr_in, 1'b1);
    at_rise(2); chk("R3 latch reopens", arr_in, 1'b0);

    // R4 bypass
    cap_mode = 2'b00; pad_i = 1; #1;
    chk("R4 bypass follows 00", arr_in, 1'b1);
    cap_mode = 2'b11; pad_i = 0; #1;
    chk("R4 bypass follows 11", arr_in, 1'b0);

    // R5 inverted polarity flop
    clk_inv = 1; cap_mode = 2'b01; pad_i = 0;
    at_rise(5); at_rise(5); pad_i = 1; #3;
    chk("R5 inv flop no load on rise", arr_in, 1'b0);
    #9; chk("R5 inv flop loads on fall", arr_in, 1'b1);

    // R5 inverted latch, transparent while clk low
    cap_mode = 2'b10;
    at_rise(5); pad_i = 0; #1;
    chk("R5 inv latch holds while high", arr_in, 1'b1);
    #9; chk("R5 inv latch open while low", arr_in, 1'b0);
    clk_inv = 0;

    // R8 buried register
    cap_mode = 2'b01; ded_out = 1; sum_d = 1; pad_i = 0;
    at_rise(5); at_rise(5);
    chk("R8 buried takes sum_d", arr_in, 1'b1);
    pad_i = 1; sum_d = 0;
    at_rise(5); chk("R8 pad ignored", arr_in, 1'b0);
    ded_out = 0;
    at_rise(5); chk("R8 pad source restored", arr_in, 1'b1);

    // R1 async clear mid-cycle
    #2; rst_n = 0; #1;
    chk("R1 async clear", arr_in, 1'b0);
    rst_n = 1;

    // R9 input cell with all output controls active
    oe = 1; out_inv = 1; lc_out = 8'hFF; #1;
    chk("R9 input cell stays off", pad_oe2 | pad_o2, 1'b0);
    chk("R7 enabled", pad_oe, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule